// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a bus-mapped up-counter with one compare channel. A prescale counter divides the clock. Each time that counter reaches the programmed prescale value it restarts from zero, and the main counter advances by one. Software can read the main counter at any time.

The compare channel watches the step the main counter is about to take. When the next value equals the compare value, the channel can do up to three things, each selected by its own bit:
- raise a sticky interrupt flag;
- send the counter to zero instead;
- turn the counting enable off.

The interrupt output is a level signal. It stays high until software clears the flag by writing a one to it.

The block is driven by a plain register bus: an address, a write strobe, write data and combinational read data. Only internal-clock counting is provided.

Top module: `match_timer`

## Requirements
- R1: After synchronous reset every register reads zero and `irq` is low.
- R2: While enabled and not held, the main counter advances once every PSC+1 clock cycles, where PSC is the prescale register. With PSC = 0 it advances on every clock.
- R3: In the control register (offset 0x004), bit 0 enables counting. Bit 1 keeps both the main counter and the prescale counter at zero for as long as it is set, and it overrides bit 0.
- R4: The match-action register is at offset 0x014. If its bit 0 is set, the interrupt flag sets on the very edge on which the counter steps to the compare value (offset 0x018). The flag reads as bit 0 at offset 0x000. If bit 0 of the match-action register is clear, a match leaves the flag alone.
- R5: If bit 1 of the match-action register is set, a match sends the counter to zero instead of to the compare value.
- R6: If bit 2 of the match-action register is set, a match clears enable bit 0 of the control register, and the counter then stays frozen.
- R7: Writing 1 to bit 0 at offset 0x000 clears the flag, and writing 0 leaves it unchanged. A match on the same edge as a clearing write wins, so the flag stays set.
- R8: `irq` is high exactly while the interrupt flag is set.
- R9: Writes to the counter (offset 0x008) are ignored. Unmapped offsets read zero and ignore writes. The count-mode register (offset 0x070) supports only timer mode and always reads zero.
- R10: The counter wraps from its all-ones value to zero modulo 2^CNT_W when no match action intervenes.
- R11: The offsets are fixed as follows: flag 0x000, control 0x004, counter 0x008, prescale 0x00C, match actions 0x014, compare value 0x018, count mode 0x070.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt, high while the match flag is set |

## Verification
The properties assume that the bus presents at most one write per clock, and that the address and write data are stable around the rising edge. The bench meets this by changing bus inputs only on the falling edge and by holding the strobe for one cycle only. The properties also assume that software writes only bits 0 and 1 of the control register. Reads are taken in the low phase and never disturb state.

// File: rtl/mt_pkg.sv
// Package: register offsets and the match-action field layout shared by the
// timer's pieces. Assumes a byte-addressed map with word-aligned registers.
package mt_pkg;
    localparam int BUS_W = 32;

    localparam int unsigned OFS_FLAG  = 32'h000;
    localparam int unsigned OFS_CTRL  = 32'h004;
    localparam int unsigned OFS_COUNT = 32'h008;
    localparam int unsigned OFS_PSC   = 32'h00C;
    localparam int unsigned OFS_ACT   = 32'h014;
    localparam int unsigned OFS_CMP   = 32'h018;
    localparam int unsigned OFS_MODE  = 32'h070;

    // Match-action bits: bit 2 halt, bit 1 zero the counter, bit 0 flag.
    typedef struct packed {
        logic halt;
        logic zero_cnt;
        logic raise_flag;
    } match_act_t;
endpackage

// File: rtl/mt_prescaler.sv
// Module: prescale divider. It counts clocks while run is high. When the count
// equals limit it emits a one-cycle tick and restarts from zero. hold forces
// the count to zero and suppresses the tick. Assumes limit is stable while
// running; a limit lowered below the current count waits for a wrap.
module mt_prescaler #(
    parameter int PSC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic [PSC_W-1:0] limit,
    output logic             tick
);
    logic [PSC_W-1:0] div_q;

    // Tick when running, not held and the divider has reached its limit.
    always_comb tick = run && !hold && (div_q == limit);

    // Advance or restart the divider.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/mt_counter.sv
// Module: main up-counter with compare. On each tick the counter looks at its
// next value. If that value equals cmp_val, match_evt pulses for this cycle,
// and the counter takes zero instead when zero_on_match is set. hold keeps the
// counter at zero. Assumes tick never arrives while hold is high.
module mt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic             zero_on_match,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             match_evt
);
    logic [CNT_W-1:0] step_val;

    // Next value and compare against it.
    always_comb begin
        step_val  = count + 1'b1;
        match_evt = tick && (step_val == cmp_val);
    end

    // Update the counter on ticks; held or reset forces zero.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            count <= '0;
        end else if (tick) begin
            count <= (match_evt && zero_on_match) ? '0 : step_val;
        end
    end
endmodule

// File: rtl/mt_regs.sv
// Module: register file and bus decode. It holds the control, prescale,
// match-action and compare registers and the sticky match flag, and it muxes
// read data. Assumes one write per cycle and word-aligned offsets; any other
// address is unmapped. The counter value is only read here, never written.
module mt_regs
    import mt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              match_evt,
    output logic              run_en,
    output logic              hold_zero,
    output logic [PSC_W-1:0]  psc_val,
    output match_act_t        act,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              flag
);
    localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_PSC   = ADDR_W'(OFS_PSC);
    localparam logic [ADDR_W-1:0] A_ACT   = ADDR_W'(OFS_ACT);
    localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(OFS_CMP);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);

    logic             wr_flag, wr_ctrl, wr_psc, wr_act, wr_cmp;
    logic [BUS_W-1:0] count_ext, psc_ext, cmp_ext;

    // Write strobes per register.
    always_comb begin
        wr_flag = bus_we && (bus_addr == A_FLAG);
        wr_ctrl = bus_we && (bus_addr == A_CTRL);
        wr_psc  = bus_we && (bus_addr == A_PSC);
        wr_act  = bus_we && (bus_addr == A_ACT);
        wr_cmp  = bus_we && (bus_addr == A_CMP);
    end

    // Zero-extend the narrower fields to the bus width.
    generate
        if (CNT_W < BUS_W) begin : g_cnt_narrow
            assign count_ext = {{(BUS_W-CNT_W){1'b0}}, count};
            assign cmp_ext   = {{(BUS_W-CNT_W){1'b0}}, cmp_val};
        end else begin : g_cnt_full
            assign count_ext = count;
            assign cmp_ext   = cmp_val;
        end
        if (PSC_W < BUS_W) begin : g_psc_narrow
            assign psc_ext = {{(BUS_W-PSC_W){1'b0}}, psc_val};
        end else begin : g_psc_full
            assign psc_ext = psc_val;
        end
    endgenerate

    // Control register; a halting match overrides a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en    <= 1'b0;
            hold_zero <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run_en    <= bus_wdata[0];
                hold_zero <= bus_wdata[1];
            end
            if (match_evt && act.halt) begin
                run_en <= 1'b0;
            end
        end
    end

    // Configuration registers: prescale, match actions, compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_val <= '0;
            act     <= '0;
            cmp_val <= '0;
        end else begin
            if (wr_psc) psc_val <= bus_wdata[PSC_W-1:0];
            if (wr_act) act     <= match_act_t'(bus_wdata[2:0]);
            if (wr_cmp) cmp_val <= bus_wdata[CNT_W-1:0];
        end
    end

    // Sticky flag: a new match takes priority over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (match_evt && act.raise_flag) begin
            flag <= 1'b1;
        end else if (wr_flag && bus_wdata[0]) begin
            flag <= 1'b0;
        end
    end

    // Read mux; the mode register and unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_FLAG:  bus_rdata = {{(BUS_W-1){1'b0}}, flag};
            A_CTRL:  bus_rdata = {{(BUS_W-2){1'b0}}, hold_zero, run_en};
            A_COUNT: bus_rdata = count_ext;
            A_PSC:   bus_rdata = psc_ext;
            A_ACT:   bus_rdata = {{(BUS_W-3){1'b0}}, act};
            A_CMP:   bus_rdata = cmp_ext;
            A_MODE:  bus_rdata = '0;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/match_timer.sv
// Module: top of the prescaled match timer. It joins the register file, the
// prescale divider and the main counter, and drives the level interrupt from
// the sticky flag. Assumes a single clock domain and a synchronous active-low
// reset.
module match_timer
    import mt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic             run_en, hold_zero, tick, match_evt, flag;
    logic [PSC_W-1:0] psc_val;
    logic [CNT_W-1:0] cmp_val, count;
    match_act_t       act;
    logic [2:0]       act_bits;

    mt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .match_evt (match_evt),
        .run_en    (run_en),
        .hold_zero (hold_zero),
        .psc_val   (psc_val),
        .act       (act),
        .cmp_val   (cmp_val),
        .flag      (flag)
    );

    mt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en),
        .hold  (hold_zero),
        .limit (psc_val),
        .tick  (tick)
    );

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .hold          (hold_zero),
        .zero_on_match (act.zero_cnt),
        .cmp_val       (cmp_val),
        .count         (count),
        .match_evt     (match_evt)
    );

    // Interrupt is the OR of the (single) flag; action bits exposed for checks.
    always_comb begin
        irq      = flag;
        act_bits = act;
    end
endmodule

// File: rtl/mt_checker.sv
// Module: temporal checks for match_timer, attached to the top with bind.
// Assumes the bus writes at most once per cycle.
module mt_checker #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              run_en,
    input logic              hold_zero,
    input logic [2:0]        act_bits,
    input logic [CNT_W-1:0]  count,
    input logic              tick,
    input logic              match_evt
);
    // R2: without a tick (and not held) the counter holds its value.
    a_r2_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold_zero) |=> $stable(count));

    // R3: while held, the counter is zero on the next cycle.
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold_zero |=> (count == '0));

    // R4: the interrupt only rises after an enabled match.
    a_r4_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(match_evt && act_bits[0]));

    // R5: a match with zeroing selected leaves the counter at zero.
    a_r5_zero_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && act_bits[1]) |=> (count == '0));

    // R6: a match with halting selected drops the enable.
    a_r6_halt_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && act_bits[2]) |=> !run_en);

    // R7: a clearing write with no competing match drops the interrupt.
    a_r7_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(0) && bus_wdata[0] && !match_evt) |=> !irq);

    // R7: a match that raises the flag always leaves the interrupt high.
    a_r7_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && act_bits[0]) |=> irq);
endmodule

bind match_timer mt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run_en    (run_en),
    .hold_zero (hold_zero),
    .act_bits  (act_bits),
    .count     (count),
    .tick      (tick),
    .match_evt (match_evt)
);

// File: tb/match_timer_test.sv
// Bench: a vector loop over prescale settings, then directed match, hold,
// wrap and bus corner cases. Inputs change at falling edges.
module match_timer_test;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 12;
    localparam int NV     = 5;
    localparam int VEC_PSC [NV] = '{0, 1, 3, 4, 2};
    localparam int VEC_K   [NV] = '{5, 7, 10, 4, 9};
    localparam int VEC_EXP [NV] = '{5, 3, 2, 0, 3};

    localparam logic [ADDR_W-1:0] A_FLAG  = 12'h000;
    localparam logic [ADDR_W-1:0] A_CTRL  = 12'h004;
    localparam logic [ADDR_W-1:0] A_COUNT = 12'h008;
    localparam logic [ADDR_W-1:0] A_PSC   = 12'h00C;
    localparam logic [ADDR_W-1:0] A_ACT   = 12'h014;
    localparam logic [ADDR_W-1:0] A_CMP   = 12'h018;
    localparam logic [ADDR_W-1:0] A_MODE  = 12'h070;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata, rdata_w;
    logic              irq, irq_w;
    int                n_chk = 0;
    int                n_err = 0;
    bit                done = 1'b0;

    match_timer #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    // Narrow-counter copy used only to observe wrap-around (R10).
    match_timer #(.ADDR_W(ADDR_W), .CNT_W(4)) uut_w (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_w), .irq(irq_w));

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called in the low phase; the write lands on the next rising edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic restart();
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_COUNT, v); check("R1 count", v, 0);
        rd(A_PSC, v);   check("R1 psc", v, 0);
        rd(A_FLAG, v);  check("R1 flag", v, 0);
        check("R1 irq", 32'(irq), 0);

        // R2: prescale vectors
        for (int i = 0; i < NV; i++) begin
            wr(A_PSC, VEC_PSC[i]);
            restart();
            repeat (VEC_K[i]) @(negedge clk);
            rd(A_COUNT, v);
            check($sformatf("R2 psc=%0d", VEC_PSC[i]), v, VEC_EXP[i]);
        end

        // R3: hold bit overrides enable
        wr(A_PSC, 0);
        wr(A_CTRL, 32'h3);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v); check("R3 held count", v, 0);
        rd(A_CTRL, v);  check("R3 ctrl readback", v, 3);

        // R10: wrap on the 4-bit copy after 20 steps
        wr(A_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        bus_addr = A_COUNT; #1;
        check("R10 wrap narrow", rdata_w, 4);
        check("R2 wide count", bus_rdata, 20);

        // R4, R8: flag and irq on match with flagging only
        wr(A_CMP, 5);
        wr(A_ACT, 32'h1);
        restart();
        repeat (4) @(negedge clk);
        rd(A_COUNT, v); check("R4 before match", v, 4);
        rd(A_FLAG, v);  check("R4 flag before", v, 0);
        check("R8 irq before", 32'(irq), 0);
        @(negedge clk);
        rd(A_COUNT, v); check("R4 count at match", v, 5);
        rd(A_FLAG, v);  check("R4 flag at match", v, 1);
        check("R8 irq at match", 32'(irq), 1);

        // R7: write zero keeps flag, write one clears it
        wr(A_FLAG, 0);
        rd(A_FLAG, v); check("R7 write zero", v, 1);
        wr(A_FLAG, 1);
        rd(A_FLAG, v); check("R7 write one", v, 0);
        check("R8 irq cleared", 32'(irq), 0);

        // R5: zero on match
        wr(A_CMP, 3);
        wr(A_ACT, 32'h3);
        restart();
        repeat (3) @(negedge clk);
        rd(A_COUNT, v); check("R5 zeroed", v, 0);
        rd(A_FLAG, v);  check("R5 flag", v, 1);
        @(negedge clk);
        rd(A_COUNT, v); check("R5 resumes", v, 1);

        // R6: halt on match, no flag without bit 0
        wr(A_ACT, 32'h4);
        wr(A_FLAG, 1);
        wr(A_CMP, 4);
        restart();
        repeat (10) @(negedge clk);
        rd(A_COUNT, v); check("R6 frozen", v, 4);
        rd(A_CTRL, v);  check("R6 enable cleared", v, 0);
        rd(A_FLAG, v);  check("R4 no flag when disabled", v, 0);
        check("R8 irq low", 32'(irq), 0);

        // R9: read-only counter, unmapped offsets, mode register
        wr(A_COUNT, 32'h55);
        rd(A_COUNT, v); check("R9 count read-only", v, 4);
        wr(12'h010, 32'hDEAD_BEEF);
        rd(12'h010, v); check("R9 unmapped read", v, 0);
        rd(12'h0FC, v); check("R9 unmapped far", v, 0);
        wr(A_MODE, 32'h3);
        rd(A_MODE, v);  check("R9 mode reads zero", v, 0);
        rd(A_COUNT, v); check("R9 count untouched", v, 4);

        // R11: offsets distinct in readback
        wr(A_PSC, 32'h0000_0077);
        rd(A_PSC, v);   check("R11 psc offset", v, 32'h77);
        rd(A_ACT, v);   check("R11 act offset", v, 4);
        rd(A_CMP, v);   check("R11 cmp offset", v, 4);
        wr(A_PSC, 0);

        // R7: match and clear on the same edge, match wins
        wr(A_ACT, 32'h1);
        wr(A_CMP, 3);
        wr(A_FLAG, 1);
        restart();
        repeat (2) @(negedge clk);
        wr(A_FLAG, 1);
        rd(A_FLAG, v); check("R7 match beats clear", v, 1);
        wr(A_FLAG, 1);
        rd(A_FLAG, v); check("R7 later clear", v, 0);

        finish_run();
    end
endmodule